// File: doc/BRIEF.md
# Block DMA Burst Planner

This block moves whole 512-byte blocks between a one-block local word buffer and system memory. It splits each block into bus bursts so that no burst crosses a line of `BURST_BYTES` bytes. It is started with a byte address, a block count and a direction. From these it works out the word count and address of every burst. It then issues the command flits on a valid/ready command channel, advances the address and buffer index, and packs words into 32-bit or 64-bit flits. It counts bursts and blocks and finishes with either success or error.

The word offset inside a line is `(start_addr / 4) mod (BURST_BYTES / 4)`. It is fixed for the whole transfer, because a block is a whole number of lines. An aligned start gives full-length bursts only. An unaligned start shortens the first burst so that it reaches the next line boundary, and adds one short burst at the end of each block.

There are two directions:
- **to-memory:** each burst is a run of write flits carrying buffer words, followed by a single response flit.
- **from-memory:** each burst is one read command flit. It is answered by a run of response flits, and the block writes each of them into the buffer.

Top module: `blk_burst_dma`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `cmd_valid` and `rsp_ready` are all low.
- R2: When `start` is high and the block is idle with a nonzero `nblocks`, `busy` is high and `done`/`err` are low one cycle later. When `start` is high while `busy` is high, it is ignored: the transfer in progress keeps its address, count and direction.
- R3: A start with `nblocks` equal to 0 sets `done` high and `err` low one cycle later. No command is issued.
- R4: With word offset 0, each block takes exactly 512/`BURST_BYTES` bursts, each of `BURST_BYTES`/4 words.
- R5: With a nonzero word offset `o`, each block takes 512/`BURST_BYTES`+1 bursts. The first carries `BURST_BYTES`/4−`o` words, the last carries `o` words, and every other burst is full length.
- R6: Every flit of a burst shows `cmd_len` equal to the burst word count times 4.
- R7: In the to-memory direction (`to_mem`=1, `cmd_write`=1), the flits work as follows.
  - On a 64-bit bus, a flit carries two words: the lower buffer index goes in bits 31:0, the next index in bits 63:32, and `cmd_be` is 0xFF.
  - When one word remains on a 64-bit bus, it goes in bits 31:0, bits 63:32 are zero, and `cmd_be` is 0x0F.
  - On a 32-bit bus, every flit carries one word with `cmd_be` 0xF.
  - The address grows by 4 bytes per word carried. Block k begins at the word-aligned start address plus 512·k.
- R8: `cmd_last` is high exactly on the flit that carries the last remaining word or words of the burst.
- R9: In the from-memory direction (`to_mem`=0), each burst is one flit with `cmd_write`=0 and `cmd_last`=1. Each accepted response flit asserts `buf_wr_en` at the current buffer index. `buf_wr_two` is high when the bus is 64-bit and at least two words of the burst remain. The burst ends on the response flit with `rsp_last` high.
- R10: The buffer index starts at 0 for every block and grows by the number of words each flit carries.
- R11: An accepted response flit with `rsp_err` high ends the transfer at once: `done`=1, `err`=1, `busy`=0, no buffer write, and no further command.
- R12: After the last burst of the last block is answered without error, `done`=1 and `err`=0. Both hold until the next accepted start.
- R13: No command crosses a `BURST_BYTES` line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, acted on only when idle |
| to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| start_addr | input | ADDR_W | Memory byte address of the first block |
| nblocks | input | NBLK_W | Number of 512-byte blocks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished, held until next start |
| err | output | 1 | Transfer ended on an error response, held until next start |
| cmd_valid | output | 1 | Command flit valid |
| cmd_ready | input | 1 | Command flit accepted |
| cmd_write | output | 1 | 1: write flit with data, 0: read request |
| cmd_addr | output | ADDR_W | Byte address of this flit |
| cmd_len | output | $clog2(BURST_BYTES+1) | Burst length in bytes |
| cmd_data | output | 8·BUS_BYTES | Write data |
| cmd_be | output | BUS_BYTES | Byte enables of a write flit |
| cmd_last | output | 1 | Last flit of the burst |
| rsp_valid | input | 1 | Response flit valid |
| rsp_ready | output | 1 | Response flit accepted |
| rsp_data | input | 8·BUS_BYTES | Read data |
| rsp_err | input | 1 | Error flag of the response |
| rsp_last | input | 1 | Last response flit of the burst |
| buf_rd_idx | output | 7 | Buffer word index for outgoing data |
| buf_rd_lo | input | 32 | Buffer word at buf_rd_idx |
| buf_rd_hi | input | 32 | Buffer word at buf_rd_idx+1 |
| buf_wr_en | output | 1 | Write incoming data to the buffer |
| buf_wr_idx | output | 7 | Buffer word index of the write |
| buf_wr_data | output | 8·BUS_BYTES | Data to write, lower word at buf_wr_idx |
| buf_wr_two | output | 1 | Write covers two words |

## Verification
The assertions assume that the memory side behaves as a well-formed responder:
- it never raises `rsp_valid` except when the block shows `rsp_ready`;
- in the to-memory direction it sends exactly one response flit per burst;
- in the from-memory direction it raises `rsp_last` on the flit that completes the advertised byte length.

The stimulus keeps to these rules because the responder is written in the bench. It answers only after the last command flit of a burst, and it sizes each read response from the word count it expects for that burst. The responder inserts random ready stalls, but it never withdraws a flit while that flit is held. Start pulses while busy, and error flags on chosen bursts, are the only deliberate irregular inputs.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLAN = 2'd1,
    ST_CMD  = 2'd2,
    ST_RSP  = 2'd3
  } bdp_state_e;

  localparam int BLOCK_BYTES = 512;

  // Words in burst number bidx of a block, given the line word offset.
  function automatic int burst_words(input int off, input int bidx,
                                     input int wpb, input int bpb);
    if (off == 0)    return wpb;
    if (bidx == 0)   return wpb - off;
    if (bidx == bpb) return off;
    return wpb;
  endfunction

  // Whether burst number bidx closes a block.
  function automatic logic burst_is_last(input int off, input int bidx, input int bpb);
    return (off == 0) ? (bidx == bpb - 1) : (bidx == bpb);
  endfunction

  // Words moved by one flit when rem words of the burst are left.
  function automatic int flit_words(input int rem, input int wpf);
    return (wpf >= 2 && rem >= 2) ? 2 : 1;
  endfunction

endpackage

// File: rtl/bdp_burst_len.sv
module bdp_burst_len #(
  parameter int WPB = 8,
  parameter int BPB = 16,
  parameter int OFW = 3,
  parameter int BCW = 5,
  parameter int WCW = 4
) (
  input  logic [OFW-1:0] off,
  input  logic [BCW-1:0] bidx,
  output logic [WCW-1:0] nwords,
  output logic           last
);
  always_comb begin
    nwords = WCW'(bdp_pkg::burst_words(int'(off), int'(bidx), WPB, BPB));
    last   = bdp_pkg::burst_is_last(int'(off), int'(bidx), BPB);
  end
endmodule

// File: rtl/bdp_flit_pack.sv
module bdp_flit_pack #(
  parameter int BUS_BYTES = 8,
  parameter int WCW       = 4
) (
  input  logic [WCW-1:0]           rem,
  input  logic [31:0]              lo,
  input  logic [31:0]              hi,
  output logic [BUS_BYTES*8-1:0]   data,
  output logic [BUS_BYTES-1:0]     be,
  output logic [1:0]               nw,
  output logic                     eop
);
  localparam int WPF = BUS_BYTES / 4;

  always_comb nw = 2'(bdp_pkg::flit_words(int'(rem), WPF));
  assign eop = (rem <= WCW'(nw));

  generate
    if (BUS_BYTES == 8) begin : g_wide
      always_comb begin
        if (nw == 2'd2) begin
          data = {hi, lo};
          be   = '1;
        end else begin
          data = {32'h0, lo};
          be   = BUS_BYTES'(8'h0F);
        end
      end
    end else begin : g_narrow
      always_comb begin
        data = lo;
        be   = '1;
      end
    end
  endgenerate
endmodule

// File: rtl/blk_burst_dma.sv
module blk_burst_dma #(
  parameter int ADDR_W      = 32,
  parameter int NBLK_W      = 16,
  parameter int BURST_BYTES = 32,
  parameter int BUS_BYTES   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              to_mem,
  input  logic [ADDR_W-1:0]                 start_addr,
  input  logic [NBLK_W-1:0]                 nblocks,
  output logic                              busy,
  output logic                              done,
  output logic                              err,
  output logic                              cmd_valid,
  input  logic                              cmd_ready,
  output logic                              cmd_write,
  output logic [ADDR_W-1:0]                 cmd_addr,
  output logic [$clog2(BURST_BYTES+1)-1:0]  cmd_len,
  output logic [BUS_BYTES*8-1:0]            cmd_data,
  output logic [BUS_BYTES-1:0]              cmd_be,
  output logic                              cmd_last,
  input  logic                              rsp_valid,
  output logic                              rsp_ready,
  input  logic [BUS_BYTES*8-1:0]            rsp_data,
  input  logic                              rsp_err,
  input  logic                              rsp_last,
  output logic [6:0]                        buf_rd_idx,
  input  logic [31:0]                       buf_rd_lo,
  input  logic [31:0]                       buf_rd_hi,
  output logic                              buf_wr_en,
  output logic [6:0]                        buf_wr_idx,
  output logic [BUS_BYTES*8-1:0]            buf_wr_data,
  output logic                              buf_wr_two
);
  import bdp_pkg::*;

  localparam int WPB = BURST_BYTES / 4;
  localparam int BPB = BLOCK_BYTES / BURST_BYTES;
  localparam int OFW = $clog2(WPB);
  localparam int BCW = $clog2(BPB + 2);
  localparam int WCW = $clog2(WPB + 1);
  localparam int LW  = $clog2(BURST_BYTES + 1);
  localparam int IW  = $clog2(BLOCK_BYTES / 4);
  localparam int DW  = BUS_BYTES * 8;

  bdp_state_e        st_q;
  logic              dir_q;
  logic [NBLK_W-1:0] nblk_q, blk_q;
  logic [BCW-1:0]    bcnt_q;
  logic [OFW-1:0]    off_q;
  logic [WCW-1:0]    nwords_q, wcnt_q, rem;
  logic [ADDR_W-1:0] addr_q, step;
  logic [IW-1:0]     idx_q;
  logic              done_q, err_q;

  logic [WCW-1:0]    bl_nwords;
  logic              bl_last;
  logic [DW-1:0]     pk_data;
  logic [BUS_BYTES-1:0] pk_be;
  logic [1:0]        fl_nw;
  logic              fl_eop;

  // Named internal events
  logic start_ok, cmd_fire, rsp_fire, ev_burst_end, ev_xfer_ok, last_blk;

  bdp_burst_len #(.WPB(WPB), .BPB(BPB), .OFW(OFW), .BCW(BCW), .WCW(WCW)) u_len (
    .off(off_q), .bidx(bcnt_q), .nwords(bl_nwords), .last(bl_last)
  );

  bdp_flit_pack #(.BUS_BYTES(BUS_BYTES), .WCW(WCW)) u_pack (
    .rem(rem), .lo(buf_rd_lo), .hi(buf_rd_hi),
    .data(pk_data), .be(pk_be), .nw(fl_nw), .eop(fl_eop)
  );

  assign rem          = nwords_q - wcnt_q;
  assign step         = ADDR_W'(fl_nw) << 2;
  assign last_blk     = (blk_q == nblk_q - NBLK_W'(1));
  assign start_ok     = start && (st_q == ST_IDLE);
  assign cmd_fire     = cmd_valid && cmd_ready;
  assign rsp_fire     = rsp_valid && rsp_ready;
  assign ev_burst_end = rsp_fire && !rsp_err && (dir_q || rsp_last);
  assign ev_xfer_ok   = ev_burst_end && bl_last && last_blk;

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign cmd_valid   = (st_q == ST_CMD);
  assign cmd_write   = dir_q;
  assign cmd_addr    = addr_q;
  assign cmd_len     = LW'(nwords_q) << 2;
  assign cmd_data    = dir_q ? pk_data : '0;
  assign cmd_be      = dir_q ? pk_be : '0;
  assign cmd_last    = dir_q ? fl_eop : 1'b1;
  assign rsp_ready   = (st_q == ST_RSP);
  assign buf_rd_idx  = idx_q;
  assign buf_wr_en   = rsp_fire && !dir_q && !rsp_err;
  assign buf_wr_idx  = idx_q;
  assign buf_wr_data = rsp_data;
  assign buf_wr_two  = (fl_nw == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      dir_q    <= 1'b0;
      nblk_q   <= '0;
      blk_q    <= '0;
      bcnt_q   <= '0;
      off_q    <= '0;
      nwords_q <= '0;
      wcnt_q   <= '0;
      addr_q   <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_ok) begin
            done_q <= (nblocks == '0);
            err_q  <= 1'b0;
            dir_q  <= to_mem;
            nblk_q <= nblocks;
            blk_q  <= '0;
            bcnt_q <= '0;
            idx_q  <= '0;
            off_q  <= start_addr[2 +: OFW];
            addr_q <= {start_addr[ADDR_W-1:2], 2'b00};
            if (nblocks != '0) st_q <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          nwords_q <= bl_nwords;
          wcnt_q   <= '0;
          st_q     <= ST_CMD;
        end
        ST_CMD: begin
          if (cmd_fire) begin
            if (dir_q) begin
              wcnt_q <= wcnt_q + WCW'(fl_nw);
              addr_q <= addr_q + step;
              idx_q  <= idx_q + IW'(fl_nw);
              if (fl_eop) st_q <= ST_RSP;
            end else begin
              st_q <= ST_RSP;
            end
          end
        end
        ST_RSP: begin
          if (rsp_fire) begin
            if (rsp_err) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              if (!dir_q) begin
                wcnt_q <= wcnt_q + WCW'(fl_nw);
                addr_q <= addr_q + step;
                idx_q  <= idx_q + IW'(fl_nw);
              end
              if (ev_burst_end) begin
                if (ev_xfer_ok) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                end else if (bl_last) begin
                  blk_q  <= blk_q + NBLK_W'(1);
                  bcnt_q <= '0;
                  idx_q  <= '0;
                  st_q   <= ST_PLAN;
                end else begin
                  bcnt_q <= bcnt_q + BCW'(1);
                  st_q   <= ST_PLAN;
                end
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
  parameter int BURST_BYTES = 32,
  parameter int BUS_BYTES   = 8,
  parameter int AW          = 32,
  parameter int LW          = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 err,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic                 cmd_write,
  input logic [AW-1:0]        cmd_addr,
  input logic [LW-1:0]        cmd_len,
  input logic [BUS_BYTES-1:0] cmd_be,
  input logic                 cmd_last,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic                 rsp_err,
  input logic                 ev_burst_end,
  input logic                 ev_xfer_ok
);
  localparam logic [AW-1:0] LINE_MASK = AW'(BURST_BYTES - 1);
  localparam logic [BUS_BYTES-1:0] ONE_WORD_BE = BUS_BYTES'(8'h0F);

  initial a_cfg_legal: assert ((BURST_BYTES == 8 || BURST_BYTES == 16 || BURST_BYTES == 32 ||
                                BURST_BYTES == 64) && (BUS_BYTES == 4 || BUS_BYTES == 8));

  // R13: a read request stays inside one line
  a_r13_read_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write |-> int'(cmd_addr & LINE_MASK) + int'(cmd_len) <= BURST_BYTES);

  // R13: a write flit stays inside one line
  a_r13_write_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write |-> int'(cmd_addr & LINE_MASK) + $countones(cmd_be) <= BURST_BYTES);

  // R6: length is a nonzero whole number of words no larger than a line
  a_r6_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len != '0 && int'(cmd_len) <= BURST_BYTES && cmd_len[1:0] == 2'b00);

  // R7: byte enables are one or all words
  a_r7_be_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write |-> cmd_be == '1 || cmd_be == ONE_WORD_BE);

  // R8: a stalled flit is held unchanged
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_last));

  // R2: a transfer only begins on a start request
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R11: an error response ends the transfer
  a_r11_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_err |=> done && err && !busy && !cmd_valid);

  // R12: completion flags
  a_r12_ok_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_ok |=> done && !err && !busy);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: a burst that does not finish the transfer is followed by a planning cycle
  a_r10_next_burst: assert property (@(posedge clk) disable iff (!rst_n)
    ev_burst_end && !ev_xfer_ok |=> busy && !cmd_valid && !rsp_ready);
endmodule

bind blk_burst_dma bdp_checker #(
  .BURST_BYTES(BURST_BYTES), .BUS_BYTES(BUS_BYTES), .AW(ADDR_W), .LW(LW)
) u_bdp_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_be(cmd_be), .cmd_last(cmd_last),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
  .ev_burst_end(ev_burst_end), .ev_xfer_ok(ev_xfer_ok)
);

// File: tb/test_blk_burst_dma.sv
module bdp_bench_core #(
  parameter int BUS_BYTES   = 8,
  parameter int BURST_BYTES = 32,
  parameter int SEED        = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic fin,
  output int   nchk,
  output int   nerr
);
  localparam int DW  = BUS_BYTES * 8;
  localparam int LW  = $clog2(BURST_BYTES + 1);
  localparam int WPB = BURST_BYTES / 4;
  localparam int BPB = 512 / BURST_BYTES;
  localparam int WPF = BUS_BYTES / 4;

  logic start = 0, to_mem = 0;
  logic [31:0] start_addr = '0;
  logic [15:0] nblocks = '0;
  logic busy, done, err;
  logic cmd_valid, cmd_ready = 0, cmd_write, cmd_last;
  logic [31:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic [DW-1:0] cmd_data;
  logic [BUS_BYTES-1:0] cmd_be;
  logic rsp_valid = 0, rsp_ready, rsp_err = 0, rsp_last = 0;
  logic [DW-1:0] rsp_data = '0;
  logic [6:0] buf_rd_idx, buf_wr_idx;
  logic [31:0] buf_rd_lo, buf_rd_hi;
  logic buf_wr_en, buf_wr_two;
  logic [DW-1:0] buf_wr_data;
  logic [31:0] bufm [128];

  assign buf_rd_lo = bufm[buf_rd_idx];
  assign buf_rd_hi = bufm[buf_rd_idx + 7'd1];

  blk_burst_dma #(.ADDR_W(32), .NBLK_W(16), .BURST_BYTES(BURST_BYTES), .BUS_BYTES(BUS_BYTES))
  i_blk_burst_dma (
    .clk, .rst_n, .start, .to_mem, .start_addr, .nblocks, .busy, .done, .err,
    .cmd_valid, .cmd_ready, .cmd_write, .cmd_addr, .cmd_len, .cmd_data, .cmd_be, .cmd_last,
    .rsp_valid, .rsp_ready, .rsp_data, .rsp_err, .rsp_last,
    .buf_rd_idx, .buf_rd_lo, .buf_rd_hi, .buf_wr_en, .buf_wr_idx, .buf_wr_data, .buf_wr_two
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected words of burst b (restated from R4/R5)
  function automatic int exp_words(input int off, input int b);
    if (off == 0) return WPB;
    if (b == 0) return WPB - off;
    if (b == BPB) return off;
    return WPB;
  endfunction

  task automatic wait_cmd();
    do @(negedge clk); while (!cmd_valid);
    while ($urandom % 4 == 0) @(negedge clk);
    cmd_ready = 1;
  endtask

  task automatic run_xfer(input logic [31:0] a, input int nb, input bit tm, input int err_at, input bit poke);
    int off, nbur, w, rem, nw, gb, idx;
    logic [31:0] cur;
    logic [63:0] ed, rd;
    logic [7:0] eb;
    bit hit;
    @(negedge clk);
    start = 1; to_mem = tm; start_addr = a; nblocks = 16'(nb);
    @(negedge clk);
    start = poke; start_addr = a + 32'h44; nblocks = 16'(nb + 1); to_mem = !tm;
    if (nb == 0) begin
      chk("R3", "done", 64'(done), 1);
      chk("R3", "err", 64'(err), 0);
      chk("R3", "busy", 64'(busy), 0);
      @(negedge clk);
      chk("R3", "cmd_valid", 64'(cmd_valid), 0);
      start = 0;
      return;
    end
    chk("R2", "busy after start", 64'(busy), 1);
    chk("R2", "done cleared", 64'(done), 0);
    chk("R2", "err cleared", 64'(err), 0);
    @(negedge clk);
    start = 0;
    off = (a >> 2) % WPB;
    nbur = (off != 0) ? BPB + 1 : BPB;
    cur = {a[31:2], 2'b00};
    gb = 0;
    for (int blk = 0; blk < nb; blk++) begin
      idx = 0;
      for (int b = 0; b < nbur; b++) begin
        w = exp_words(off, b);
        hit = (gb == err_at);
        if (tm) begin
          rem = w;
          while (rem > 0) begin
            nw = (WPF == 2 && rem >= 2) ? 2 : 1;
            wait_cmd();
            chk("R7", "write addr", 64'(cmd_addr), 64'(cur));
            chk("R6", "len", 64'(cmd_len), 64'(w * 4));
            chk("R7", "cmd_write", 64'(cmd_write), 1);
            chk("R8", "last", 64'(cmd_last), 64'(rem == nw));
            chk("R10", "rd idx", 64'(buf_rd_idx), 64'(idx));
            if (WPF == 1) begin ed = 64'(bufm[idx]); eb = 8'h0F; end
            else if (nw == 2) begin ed = {bufm[(idx + 1) % 128], bufm[idx]}; eb = 8'hFF; end
            else begin ed = 64'(bufm[idx]); eb = 8'h0F; end
            chk("R7", "data", 64'(cmd_data), ed);
            chk("R7", "be", 64'(cmd_be), 64'(eb));
            cur += 32'(4 * nw); idx += nw; rem -= nw;
            @(negedge clk);
            cmd_ready = 0;
          end
          while (!rsp_ready) @(negedge clk);
          rsp_valid = 1; rsp_err = hit; rsp_last = 1;
          @(negedge clk);
          rsp_valid = 0; rsp_err = 0; rsp_last = 0;
        end else begin
          wait_cmd();
          chk("R9", "read addr", 64'(cmd_addr), 64'(cur));
          chk("R6", "len", 64'(cmd_len), 64'(w * 4));
          chk("R9", "cmd_write", 64'(cmd_write), 0);
          chk("R9", "last", 64'(cmd_last), 1);
          @(negedge clk);
          cmd_ready = 0;
          rem = w;
          while (rem > 0) begin
            nw = (WPF == 2 && rem >= 2) ? 2 : 1;
            while (!rsp_ready) @(negedge clk);
            rd = {$urandom, $urandom};
            rsp_data = DW'(rd); rsp_last = (rem == nw); rsp_err = hit; rsp_valid = 1;
            #1;
            if (hit) chk("R11", "no buffer write", 64'(buf_wr_en), 0);
            else begin
              chk("R9", "buf_wr_en", 64'(buf_wr_en), 1);
              chk("R10", "wr idx", 64'(buf_wr_idx), 64'(idx));
              chk("R9", "wr two", 64'(buf_wr_two), 64'(nw == 2));
              chk("R9", "wr data", 64'(buf_wr_data[31:0]), 64'(rd[31:0]));
            end
            @(negedge clk);
            rsp_valid = 0; rsp_err = 0; rsp_last = 0;
            if (hit) break;
            rem -= nw; idx += nw; cur += 32'(4 * nw);
          end
        end
        if (hit) begin
          chk("R11", "done", 64'(done), 1);
          chk("R11", "err", 64'(err), 1);
          chk("R11", "busy", 64'(busy), 0);
          repeat (3) @(negedge clk);
          chk("R11", "no command", 64'(cmd_valid), 0);
          return;
        end
        gb++;
      end
    end
    chk("R12", "done", 64'(done), 1);
    chk("R12", "err", 64'(err), 0);
    chk("R12", "busy", 64'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R12", "done held", 64'(done), 1);
  endtask

  initial begin
    logic [31:0] a;
    int nb, off, nbur, ea;
    fin = 0; nchk = 0; nerr = 0;
    void'($urandom(SEED));
    for (int i = 0; i < 128; i++) bufm[i] = $urandom;
    @(negedge clk);
    chk("R1", "busy", 64'(busy), 0);
    chk("R1", "done", 64'(done), 0);
    chk("R1", "err", 64'(err), 0);
    chk("R1", "cmd_valid", 64'(cmd_valid), 0);
    chk("R1", "rsp_ready", 64'(rsp_ready), 0);
    while (!rst_n) @(negedge clk);
    // R4 (offset 0) and R5 (every nonzero offset), both directions
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < WPB; o++)
        run_xfer(32'h2000_0000 + 32'(o * 4) + 32'(d * 2), (o % 2) + 1, d[0], -1, o == 1);
    run_xfer(32'h0000_1234, 0, 1, -1, 0);              // R3
    run_xfer(32'h0000_0104, 2, 1, 3, 0);               // R11 first block
    run_xfer(32'h0000_0008, 2, 0, BPB + 1, 0);         // R11 second block
    run_xfer(32'h0000_0000, 1, 1, -1, 1);              // R2 after error
    for (int k = 0; k < 6; k++) begin
      a = $urandom;
      nb = 1 + int'($urandom % 3);
      off = int'((a >> 2) % WPB);
      nbur = (off != 0) ? BPB + 1 : BPB;
      ea = ($urandom % 3 == 0) ? int'($urandom % (nb * nbur)) : -1;
      run_xfer(a, nb, $urandom % 2 == 1, ea, k % 2 == 0);
    end
    fin = 1;
  end
endmodule

module test_blk_burst_dma;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic f0, f1, f2;
  int c0, c1, c2, e0, e1, e2;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bdp_bench_core #(.BUS_BYTES(8), .BURST_BYTES(32), .SEED(11)) u_w64 (
    .clk, .rst_n, .fin(f0), .nchk(c0), .nerr(e0));
  bdp_bench_core #(.BUS_BYTES(4), .BURST_BYTES(16), .SEED(23)) u_w32 (
    .clk, .rst_n, .fin(f1), .nchk(c1), .nerr(e1));
  bdp_bench_core #(.BUS_BYTES(8), .BURST_BYTES(64), .SEED(37)) u_w64l (
    .clk, .rst_n, .fin(f2), .nchk(c2), .nerr(e2));

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
  end

  initial begin
    int cyc = 0;
    int checks, errors;
    #1;
    while (!(f0 && f1 && f2) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    #1;
    checks = c0 + c1 + c2;
    errors = e0 + e1 + e2;
    if (!(f0 && f1 && f2)) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule